// File: doc/BRIEF.md
# Type III Digital Loop Compensator

This block sets the duty command for one loop of a digital buck regulator. A voltage-error converter delivers a signed error sample together with a one-cycle strobe. For each accepted sample the block applies a linear proportional-integral-derivative law and then two cascaded first-order low-pass sections. Each low-pass section has its own coefficient. A PID followed by two poles has the response of an analog Type III network. The result is clamped to an unsigned 10-bit duty word and goes to the PWM generator, marked by a one-cycle valid pulse.

All five coefficients are plain register inputs. The block reads them at the cycle where each stage uses them, so a change made between samples applies from the next sample onward. The integrator stops accumulating while the previous result was clamped in the direction the current error would push it. This keeps the integrator from winding up. A synchronous reset returns all internal state to zero.

Sequencing is a small state machine. `S_IDLE` waits for the strobe. On a strobe it latches the error (transition *accept*) and moves to `S_LAW`. `S_LAW` evaluates the PID law and always moves on (transition *law_done*) to `S_POLE` with the pole index at 0. `S_POLE` updates one pole section per cycle. It stays in `S_POLE` while sections remain (transition *next_pole*). After the last section it returns to `S_IDLE` (transition *finish*), loads the duty word and pulses the valid output.

Top module: `pid_pole_comp`

## Requirements
- R1: Synchronous reset clears the integrator, the stored previous error, both pole states, the saturation flags, `duty` (to 0) and `out_vld` (to 0). It also abandons any sample in progress, which then produces no valid pulse. The first result after reset is computed from all-zero state.
- R2: A strobe on `in_vld` is accepted only in `S_IDLE`. If `in_vld` is sampled high at edge k, `out_vld` is high for exactly the one cycle that follows edge k+3 and is low otherwise.
- R3: A strobe that arrives while a sample is in progress (at edges k+1 through k+3) is ignored. It produces no extra valid pulse and has no effect on any result.
- R4: Gains `kp`, `ki`, `kd` are unsigned with 4 fraction bits. For each sample, the integrator first becomes I = I + ki·e. The PID output is then u = floor((kp·e + I + kd·(e − e_prev)) / 16), where e_prev is the previous accepted error (0 after reset).
- R5: Each pole section computes y = y + floor(a·(x − y) / 256), where `a` is an unsigned fraction with 8 fraction bits. The first section takes u as x and `pole_a1` as a. The second section takes the first section's new y as x and `pole_a2` as a. Each section updates only once per sample.
- R6: `duty` is the second section's y clamped to the range 0 to 1023. `duty` changes only at the edge that raises `out_vld`.
- R7: Anti-windup applies when the previous result was above 1023 and e > 0, or when it was below 0 and e < 0. In either case the integrator keeps its value for that sample; otherwise it updates as in R4. The integrator also saturates at ±(2^23 − 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | One-cycle strobe marking a new error sample |
| err | input | 9 | Signed error sample |
| kp | input | 8 | Proportional gain, unsigned, 4 fraction bits |
| ki | input | 8 | Integral gain, unsigned, 4 fraction bits |
| kd | input | 8 | Derivative gain, unsigned, 4 fraction bits |
| pole_a1 | input | 8 | First pole coefficient, unsigned, 8 fraction bits |
| pole_a2 | input | 8 | Second pole coefficient, unsigned, 8 fraction bits |
| out_vld | output | 1 | One-cycle pulse: new duty word available |
| duty | output | 10 | Clamped unsigned duty command |

## Verification
A wrong integrator, a wrong previous error or a wrong pole state does not always show on the next duty word. It shows once a later sample exercises the corrupted term, three cycles after that sample's strobe, and then it keeps affecting every following result until reset. A state-machine fault shows at once as a valid pulse in the wrong cycle, a missing pulse or an extra pulse. Anti-windup faults show only on the recovery from a clamped output: the duty word comes off the rail at a different sample than expected. The bench therefore drives long saturating runs and then reverses the error.

// File: rtl/comp_pkg.sv
package comp_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LAW  = 2'd1,
        S_POLE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/comp_seq.sv
module comp_seq #(
    parameter int NPOLE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    output logic             cap_en,
    output logic             law_en,
    output logic [NPOLE-1:0] pole_en,
    output logic             out_vld
);
    import comp_pkg::*;

    localparam int IXW = (NPOLE > 1) ? $clog2(NPOLE) : 1;
    localparam logic [IXW-1:0] LAST_IX = IXW'(NPOLE - 1);

    seq_state_t     state, state_nx;
    logic [IXW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            idx     <= '0;
            out_vld <= 1'b0;
        end else begin
            state   <= state_nx;
            out_vld <= (state == S_POLE) && (idx == LAST_IX);
            if (state == S_POLE)
                idx <= (idx == LAST_IX) ? '0 : idx + 1'b1;
            else
                idx <= '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_vld) state_nx = S_LAW;
            S_LAW:   state_nx = S_POLE;
            S_POLE:  if (idx == LAST_IX) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        cap_en  = 1'b0;
        law_en  = 1'b0;
        pole_en = '0;
        unique case (state)
            S_IDLE:  cap_en = in_vld;
            S_LAW:   law_en = 1'b1;
            S_POLE:  pole_en[idx] = 1'b1;
            default: ;
        endcase
    end

    // R2
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && in_vld) |=> (state == S_LAW));
    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> (state != S_LAW));
endmodule

// File: rtl/pid_law.sv
module pid_law #(
    parameter int EW = 9,
    parameter int GW = 8,
    parameter int GF = 4,
    parameter int IW = 24,
    parameter int AW = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_en,
    input  logic                 en,
    input  logic signed [EW-1:0] err,
    input  logic        [GW-1:0] kp,
    input  logic        [GW-1:0] ki,
    input  logic        [GW-1:0] kd,
    input  logic                 sat_hi,
    input  logic                 sat_lo,
    output logic signed [AW-1:0] u
);
    localparam logic signed [AW-1:0] IMAX = AW'((64'sd1 <<< (IW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] IMIN = -IMAX;

    logic signed [EW-1:0] err_q, e_prev;
    logic signed [IW-1:0] integ, integ_nx;
    logic signed [AW-1:0] e_x, de_x, kp_x, ki_x, kd_x;
    logic signed [AW-1:0] i_sum, i_clip, total;
    logic                 hold;

    always_comb begin
        e_x    = AW'(err_q);
        de_x   = AW'(err_q) - AW'(e_prev);
        kp_x   = AW'({1'b0, kp});
        ki_x   = AW'({1'b0, ki});
        kd_x   = AW'({1'b0, kd});
        hold   = (sat_hi && (err_q > 0)) || (sat_lo && (err_q < 0));
        i_sum  = AW'(integ) + ki_x * e_x;
        if (i_sum > IMAX)
            i_clip = IMAX;
        else if (i_sum < IMIN)
            i_clip = IMIN;
        else
            i_clip = i_sum;
        integ_nx = hold ? integ : IW'(i_clip);
        total    = kp_x * e_x + AW'(integ_nx) + kd_x * de_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            e_prev <= '0;
            integ  <= '0;
            u      <= '0;
        end else begin
            if (cap_en)
                err_q <= err;
            if (en) begin
                integ  <= integ_nx;
                e_prev <= err_q;
                u      <= total >>> GF;
            end
        end
    end

    // R7
    windup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && hold) |=> $stable(integ));
    // R4
    law_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(integ) && $stable(e_prev) && $stable(u)));
endmodule

// File: rtl/pole_section.sv
module pole_section #(
    parameter int AW = 26,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [AW-1:0] x,
    input  logic        [CW-1:0] a,
    output logic signed [AW-1:0] y,
    output logic signed [AW-1:0] y_nx
);
    localparam int PW = AW + CW + 2;

    logic signed [PW-1:0] diff, a_x, prod, step;

    always_comb begin
        diff = PW'(x) - PW'(y);
        a_x  = PW'({1'b0, a});
        prod = diff * a_x;
        step = prod >>> CW;
        y_nx = y + AW'(step);
    end

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (en)
            y <= y_nx;
    end

    // R5
    pole_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(y));
endmodule

// File: rtl/pid_pole_comp.sv
module pid_pole_comp #(
    parameter int EW = 9,
    parameter int GW = 8,
    parameter int GF = 4,
    parameter int CW = 8,
    parameter int DW = 10,
    parameter int IW = 24,
    parameter int AW = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [EW-1:0] err,
    input  logic        [GW-1:0] kp,
    input  logic        [GW-1:0] ki,
    input  logic        [GW-1:0] kd,
    input  logic        [CW-1:0] pole_a1,
    input  logic        [CW-1:0] pole_a2,
    output logic                 out_vld,
    output logic        [DW-1:0] duty
);
    localparam int NPOLE = 2;
    localparam logic signed [AW-1:0] DMAX = AW'((64'sd1 <<< DW) - 64'sd1);

    logic             cap_en, law_en;
    logic [NPOLE-1:0] pole_en;
    logic signed [AW-1:0] u;
    logic signed [AW-1:0] xin  [NPOLE];
    logic signed [AW-1:0] ys   [NPOLE];
    logic signed [AW-1:0] ynx  [NPOLE];
    logic        [CW-1:0] acoef [NPOLE];
    logic signed [AW-1:0] last_nx;
    logic                 sat_hi, sat_lo;

    assign acoef[0] = pole_a1;
    assign acoef[1] = pole_a2;

    comp_seq #(.NPOLE(NPOLE)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .cap_en  (cap_en),
        .law_en  (law_en),
        .pole_en (pole_en),
        .out_vld (out_vld)
    );

    pid_law #(.EW(EW), .GW(GW), .GF(GF), .IW(IW), .AW(AW)) u_law (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .en     (law_en),
        .err    (err),
        .kp     (kp),
        .ki     (ki),
        .kd     (kd),
        .sat_hi (sat_hi),
        .sat_lo (sat_lo),
        .u      (u)
    );

    for (genvar i = 0; i < NPOLE; i++) begin : g_pole
        if (i == 0) begin : g_head
            assign xin[i] = u;
        end else begin : g_tail
            assign xin[i] = ys[i-1];
        end
        pole_section #(.AW(AW), .CW(CW)) u_sec (
            .clk  (clk),
            .rst  (rst),
            .en   (pole_en[i]),
            .x    (xin[i]),
            .a    (acoef[i]),
            .y    (ys[i]),
            .y_nx (ynx[i])
        );
    end

    assign last_nx = ynx[NPOLE-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            duty   <= '0;
            sat_hi <= 1'b0;
            sat_lo <= 1'b0;
        end else if (pole_en[NPOLE-1]) begin
            sat_hi <= last_nx > DMAX;
            sat_lo <= last_nx < 0;
            if (last_nx > DMAX)
                duty <= DMAX[DW-1:0];
            else if (last_nx < 0)
                duty <= '0;
            else
                duty <= last_nx[DW-1:0];
        end
    end

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_vld && !$past(rst)) |-> $stable(duty));
    // R6
    clamp_hi_chk: assert property (@(posedge clk) disable iff (rst)
        sat_hi |-> (duty == DMAX[DW-1:0]));
    // R6
    clamp_lo_chk: assert property (@(posedge clk) disable iff (rst)
        sat_lo |-> (duty == '0));
endmodule

// File: tb/sim_pid_pole_comp.sv
`timescale 1ns/1ps
module sim_pid_pole_comp;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic signed [8:0] err = '0;
    logic [7:0]        kp = '0, ki = '0, kd = '0, pole_a1 = '0, pole_a2 = '0;
    logic              out_vld;
    logic [9:0]        duty;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pid_pole_comp u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .err(err),
        .kp(kp), .ki(ki), .kd(kd), .pole_a1(pole_a1), .pole_a2(pole_a2),
        .out_vld(out_vld), .duty(duty)
    );

    typedef struct packed {
        logic signed [8:0] e;
        logic [7:0] kp, ki, kd, a1, a2;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{9'sd100,  8'd16,  8'd0,  8'd0,  8'd128, 8'd128},
        '{9'sd100,  8'd16,  8'd0,  8'd0,  8'd128, 8'd128},
        '{9'sd50,   8'd32,  8'd4,  8'd8,  8'd200, 8'd64},
        '{-9'sd30,  8'd32,  8'd4,  8'd8,  8'd200, 8'd64},
        '{9'sd255,  8'd255, 8'd20, 8'd40, 8'd255, 8'd255},
        '{9'sd255,  8'd255, 8'd20, 8'd40, 8'd255, 8'd255},
        '{-9'sd256, 8'd255, 8'd20, 8'd40, 8'd255, 8'd255},
        '{-9'sd256, 8'd80,  8'd9,  8'd0,  8'd255, 8'd255},
        '{9'sd7,    8'd80,  8'd9,  8'd3,  8'd0,   8'd255},
        '{9'sd7,    8'd80,  8'd9,  8'd3,  8'd17,  8'd0},
        '{9'sd120,  8'd1,   8'd1,  8'd1,  8'd1,   8'd1},
        '{-9'sd1,   8'd200, 8'd0,  8'd255,8'd90,  8'd170}
    };

    // independent reference state
    longint m_i, m_ep, m_y1, m_y2, m_duty;
    bit     m_hi, m_lo;
    localparam longint IMX = (64'sd1 <<< 23) - 1;

    task automatic model_reset();
        m_i = 0; m_ep = 0; m_y1 = 0; m_y2 = 0; m_duty = 0; m_hi = 0; m_lo = 0;
    endtask

    task automatic model_step(input longint e);
        longint u;
        if (!((m_hi && e > 0) || (m_lo && e < 0))) begin
            m_i = m_i + longint'(ki) * e;
            if (m_i > IMX) m_i = IMX;
            if (m_i < -IMX) m_i = -IMX;
        end
        u = (longint'(kp) * e + m_i + longint'(kd) * (e - m_ep)) >>> 4;
        m_ep = e;
        m_y1 = m_y1 + ((longint'(pole_a1) * (u - m_y1)) >>> 8);
        m_y2 = m_y2 + ((longint'(pole_a2) * (m_y1 - m_y2)) >>> 8);
        m_hi = m_y2 > 1023;
        m_lo = m_y2 < 0;
        m_duty = m_hi ? 1023 : (m_lo ? 0 : m_y2);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives one sample and checks valid timing and value
    task automatic send(input logic signed [8:0] e, input string req);
        @(negedge clk);
        in_vld = 1'b1; err = e;
        @(negedge clk);
        in_vld = 1'b0;
        model_step(longint'(e));
        @(negedge clk);
        chk(out_vld == 1'b0, "R2 early k+1", out_vld, 0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R2 early k+2", out_vld, 0);
        @(negedge clk);
        chk(out_vld == 1'b1, "R2 pulse k+3", out_vld, 1);
        chk(longint'(duty) == m_duty, req, duty, m_duty);
    endtask

    task automatic set_g(input logic [7:0] p, i, d, a, b);
        kp = p; ki = i; kd = d; pole_a1 = a; pole_a2 = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
        chk(duty == 10'd0, "R1 reset duty", duty, 0);
        rst = 1'b0;

        // table walk: R4 R5 R6 general behaviour
        for (int n = 0; n < NV; n++) begin
            set_g(TBL[n].kp, TBL[n].ki, TBL[n].kd, TBL[n].a1, TBL[n].a2);
            send(TBL[n].e, "R4/R5 table");
        end

        // R5 pure pole response, zero state
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; model_reset();
        set_g(8'd16, 8'd0, 8'd0, 8'd128, 8'd128);
        send(9'sd100, "R5 half-step poles");
        chk(duty == 10'd25, "R5 fixed value", duty, 25);

        // R6 low clamp
        set_g(8'd64, 8'd0, 8'd0, 8'd255, 8'd255);
        send(-9'sd200, "R6 low clamp");
        chk(duty == 10'd0, "R6 duty zero", duty, 0);

        // R7 anti-windup high side then recovery
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; model_reset();
        set_g(8'd0, 8'd255, 8'd0, 8'd255, 8'd255);
        for (int n = 0; n < 5; n++) send(9'sd255, "R7 drive high");
        chk(duty == 10'd1023, "R6 high clamp", duty, 1023);
        for (int n = 0; n < 8; n++) send(-9'sd200, "R7 recovery high");

        // R7 anti-windup low side then recovery
        for (int n = 0; n < 6; n++) send(-9'sd255, "R7 drive low");
        for (int n = 0; n < 8; n++) send(9'sd150, "R7 recovery low");

        // R4 derivative term alone
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; model_reset();
        set_g(8'd0, 8'd0, 8'd64, 8'd255, 8'd255);
        send(9'sd40, "R4 derivative first");
        send(9'sd40, "R4 derivative flat");
        send(9'sd200, "R4 derivative step");

        // R3 strobes during a busy sample are ignored
        set_g(8'd48, 8'd3, 8'd0, 8'd150, 8'd150);
        @(negedge clk); in_vld = 1'b1; err = 9'sd90;
        @(negedge clk); err = -9'sd250;
        model_step(90);
        @(negedge clk);
        chk(out_vld == 1'b0, "R3 busy k+1", out_vld, 0);
        @(negedge clk); in_vld = 1'b0;
        chk(out_vld == 1'b0, "R3 busy k+2", out_vld, 0);
        @(negedge clk);
        chk(out_vld == 1'b1, "R3 single pulse", out_vld, 1);
        chk(longint'(duty) == m_duty, "R3 value unaffected", duty, m_duty);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R3 no extra pulse", out_vld, 0);
        end
        send(9'sd10, "R3 later state unaffected");

        // R1 reset while busy abandons the sample
        @(negedge clk); in_vld = 1'b1; err = 9'sd77;
        @(negedge clk); in_vld = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; model_reset();
        chk(duty == 10'd0, "R1 duty after reset", duty, 0);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R1 no pulse after reset", out_vld, 0);
        end
        set_g(8'd16, 8'd0, 8'd16, 8'd128, 8'd128);
        send(9'sd100, "R1 fresh state");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule